// File: doc/BRIEF.md
# Sync Mode Recognition Controller

This controller decides, once per field, whether the vertical field counter runs in fixed-count mode or in sync-following mode. Fixed-count mode keeps the counter free of sync jitter. Sync-following mode lets the counter be pulled onto the incoming vertical sync, which suits sources with non-standard timing. The neighbouring counter logic supplies three values: a field-boundary strobe, a coincidence flag that says whether the incoming sync lined up with the internal count, and the number of equalizing serrations seen in the vertical-drive window of that field. The controller also watches the raw vertical sync line inside the active-scan window, so that it can detect noise.

The controller builds confidence over consecutive good fields before it commits to fixed-count mode, and it tolerates a run of bad fields before it leaves that mode. Noise during active scan, such as a tuner change, lets the controller skip the confidence wait and lock again at the next coincident field. An external select can pin the controller in sync-following mode. While the controller follows sync, each rising edge of vertical sync raises a one-cycle request that resets the field counter.

Top module: `sync_mode_ctrl`

## Requirements
- R1: After reset, `fixed_mode_o` is 0 (sync-following mode) and `cnt_reset_o` is 0.
- R2: A field is good when `coin_i` is 1 and `serr_cnt_i` is 9 or more at the boundary strobe. Any other combination is a failing field: eight serrations with coincidence, or no coincidence with any serration count.
- R3: In sync-following mode, seven consecutive good fields set `fixed_mode_o` to 1 in the cycle after the seventh strobe. Six good fields leave it at 0.
- R4: In sync-following mode, a failing field clears the confidence count, so seven further consecutive good fields are needed.
- R5: In fixed mode, six consecutive failing fields keep `fixed_mode_o` at 1, and a seventh consecutive failing field clears it. A good field restarts the failure count.
- R6: Two or more rising edges of `vsync_i` while `scan_win_i` is 1 within one field arm a fast resync. The arm stays set across non-coincident fields. At the first later boundary where `coin_i` is 1, which may be the boundary closing the noisy field itself, the controller enters fixed mode regardless of the serration count.
- R7: The noise count restarts at every field boundary. A single noise edge in a field does not arm a fast resync, nor do edges while `scan_win_i` is 0, nor single edges spread over two fields.
- R8: When `force_async_i` is 1 at a boundary, `fixed_mode_o` is 0 after that boundary, whatever the sync looks like, and the confidence is cleared.
- R9: `fixed_mode_o` changes only in the cycle after a `field_end_i` strobe.
- R10: In sync-following mode, a rising edge of `vsync_i` gives a one-cycle `cnt_reset_o` pulse one cycle later. In fixed mode no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| field_end_i | input | 1 | One-cycle field boundary strobe |
| coin_i | input | 1 | Sync coincided with the internal count in this field |
| serr_cnt_i | input | 4 | Equalizing serrations seen in the drive window of this field |
| scan_win_i | input | 1 | Active-scan window, in which noise is counted |
| vsync_i | input | 1 | Raw vertical sync, used for noise detection and counter reset |
| force_async_i | input | 1 | Forces sync-following mode |
| fixed_mode_o | output | 1 | 1 for fixed-count mode, 0 for sync-following mode |
| cnt_reset_o | output | 1 | One-cycle request to reset the field counter |

## Verification
The bench sweeps every serration count, with and without coincidence, over a full seven-field entry run. A threshold off by one would then enter fixed mode on eight serrations or refuse it on nine. It places a good field in the middle of a failing run, and a failing field in the middle of a confidence run. A design that fails to clear the counters on the opposite outcome would then switch mode a field early. The bench also checks that noise arms only with two edges inside the window of a single field. A design that never cleared the noise count, or that ignored the window, would then resync falsely. Finally, the bench compares the counter reset request in both modes; a design that gated it wrongly would pull a locked counter off its count.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;
  typedef enum logic {
    MODE_FOLLOW = 1'b0,
    MODE_FIXED  = 1'b1
  } mode_e;
endpackage

// File: rtl/mode_sat_cnt.sv
module mode_sat_cnt #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (inc_i && cnt_q != MAX)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_sat_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && inc_i && !clr_i) |=> cnt_q == MAX);
  assert_clr_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/sync_noise_det.sv
module sync_noise_det #(
  parameter int NOISE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vsync_i,
  input  logic               scan_win_i,
  input  logic               field_end_i,
  output logic               sync_rise_o,
  output logic [NOISE_W-1:0] noise_cnt_o
);
  localparam logic [NOISE_W-1:0] NMAX = '1;

  logic               vsync_q;
  logic [NOISE_W-1:0] noise_q;

  assign sync_rise_o = vsync_i & ~vsync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsync_q <= 1'b0;
      noise_q <= '0;
    end else begin
      vsync_q <= vsync_i;
      if (field_end_i)
        noise_q <= '0;
      else if (sync_rise_o && scan_win_i && noise_q != NMAX)
        noise_q <= noise_q + 1'b1;
    end
  end

  assign noise_cnt_o = noise_q;

  assert_noise_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_end_i |=> noise_q == '0);
  assert_noise_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_win_i && !field_end_i) |=> $stable(noise_q));
endmodule

// File: rtl/sync_mode_fsm.sv
module sync_mode_fsm
  import sync_mode_pkg::*;
#(
  parameter int CNT_W        = 3,
  parameter int ENTER_FIELDS = 7,
  parameter int EXIT_FIELDS  = 7,
  parameter int SERR_W       = 4,
  parameter int MIN_SERR     = 9,
  parameter int NOISE_W      = 3,
  parameter int NOISE_MIN    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               field_end_i,
  input  logic               coin_i,
  input  logic [SERR_W-1:0]  serr_i,
  input  logic [NOISE_W-1:0] noise_cnt_i,
  input  logic               force_async_i,
  output mode_e              mode_o
);
  localparam logic [SERR_W-1:0]  SERR_TH   = SERR_W'(MIN_SERR);
  localparam logic [NOISE_W-1:0] NOISE_TH  = NOISE_W'(NOISE_MIN);
  localparam logic [CNT_W-1:0]   ENTER_TOP = CNT_W'(ENTER_FIELDS - 1);
  localparam logic [CNT_W-1:0]   EXIT_TOP  = CNT_W'(EXIT_FIELDS - 1);

  mode_e       mode_q, mode_d;
  logic        arm_q, arm_d;
  logic        good, fast;
  logic        conf_clr, conf_inc, miss_clr, miss_inc;
  logic [CNT_W-1:0] conf_cnt, miss_cnt;

  assign good = coin_i && (serr_i >= SERR_TH);
  assign fast = arm_q || (noise_cnt_i >= NOISE_TH);

  always_comb begin
    mode_d   = mode_q;
    arm_d    = arm_q;
    conf_clr = 1'b0;
    conf_inc = 1'b0;
    miss_clr = 1'b0;
    miss_inc = 1'b0;
    if (field_end_i) begin
      if (mode_q == MODE_FOLLOW) begin
        miss_clr = 1'b1;
        if (force_async_i) begin
          conf_clr = 1'b1;
          arm_d    = 1'b0;
        end else if ((good && conf_cnt == ENTER_TOP) || (coin_i && fast)) begin
          mode_d   = MODE_FIXED;
          conf_clr = 1'b1;
          arm_d    = 1'b0;
        end else begin
          conf_inc = good;
          conf_clr = !good;
          arm_d    = fast;
        end
      end else begin
        conf_clr = 1'b1;
        arm_d    = 1'b0;
        if (force_async_i) begin
          mode_d   = MODE_FOLLOW;
          miss_clr = 1'b1;
        end else if (good) begin
          miss_clr = 1'b1;
        end else if (miss_cnt == EXIT_TOP) begin
          mode_d   = MODE_FOLLOW;
          miss_clr = 1'b1;
        end else begin
          miss_inc = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_FOLLOW;
      arm_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      arm_q  <= arm_d;
    end
  end

  mode_sat_cnt #(.W(CNT_W)) i_conf_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(conf_clr), .inc_i(conf_inc), .cnt_o(conf_cnt)
  );

  mode_sat_cnt #(.W(CNT_W)) i_miss_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(miss_clr), .inc_i(miss_inc), .cnt_o(miss_cnt)
  );

  assign mode_o = mode_q;

  assert_mode_at_boundary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_end_i |=> $stable(mode_q));
  assert_force_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_end_i && force_async_i) |=> mode_q == MODE_FOLLOW);
  assert_exit_seventh_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_end_i && mode_q == MODE_FIXED && !good && miss_cnt == EXIT_TOP)
      |=> mode_q == MODE_FOLLOW);
  assert_hold_on_good_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_end_i && mode_q == MODE_FIXED && good && !force_async_i)
      |=> mode_q == MODE_FIXED);
  assert_fast_enter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_end_i && mode_q == MODE_FOLLOW && !force_async_i && coin_i && fast)
      |=> mode_q == MODE_FIXED);
  assert_no_arm_in_fixed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_FIXED && field_end_i) |=> !arm_q);
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
  import sync_mode_pkg::*;
#(
  parameter int CNT_W        = 3,
  parameter int ENTER_FIELDS = 7,
  parameter int EXIT_FIELDS  = 7,
  parameter int SERR_W       = 4,
  parameter int MIN_SERR     = 9,
  parameter int NOISE_W      = 3,
  parameter int NOISE_MIN    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              field_end_i,
  input  logic              coin_i,
  input  logic [SERR_W-1:0] serr_cnt_i,
  input  logic              scan_win_i,
  input  logic              vsync_i,
  input  logic              force_async_i,
  output logic              fixed_mode_o,
  output logic              cnt_reset_o
);
  logic               sync_rise;
  logic [NOISE_W-1:0] noise_cnt;
  mode_e              mode;
  logic               rst_req_q;

  sync_noise_det #(.NOISE_W(NOISE_W)) i_noise (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vsync_i    (vsync_i),
    .scan_win_i (scan_win_i),
    .field_end_i(field_end_i),
    .sync_rise_o(sync_rise),
    .noise_cnt_o(noise_cnt)
  );

  sync_mode_fsm #(
    .CNT_W(CNT_W), .ENTER_FIELDS(ENTER_FIELDS), .EXIT_FIELDS(EXIT_FIELDS),
    .SERR_W(SERR_W), .MIN_SERR(MIN_SERR), .NOISE_W(NOISE_W), .NOISE_MIN(NOISE_MIN)
  ) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .field_end_i  (field_end_i),
    .coin_i       (coin_i),
    .serr_i       (serr_cnt_i),
    .noise_cnt_i  (noise_cnt),
    .force_async_i(force_async_i),
    .mode_o       (mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= sync_rise && (mode == MODE_FOLLOW);
  end

  assign fixed_mode_o = (mode == MODE_FIXED);
  assign cnt_reset_o  = rst_req_q;

  assert_req_follow_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_FIXED) |=> !rst_req_q);
  assert_req_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> !rst_req_q);
endmodule

// File: tb/test_sync_mode_ctrl.sv
module test_sync_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fe = 1'b0, coin = 1'b0, scan = 1'b0, vs = 1'b0, frc = 1'b0;
  logic [3:0] serr = '0;
  logic fixed, creq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_mode_ctrl i_sync_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .field_end_i(fe), .coin_i(coin),
    .serr_cnt_i(serr), .scan_win_i(scan), .vsync_i(vs),
    .force_async_i(frc), .fixed_mode_o(fixed), .cnt_reset_o(creq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic field(input logic c, input logic [3:0] s);
    @(negedge clk); coin = c; serr = s; fe = 1'b1;
    @(negedge clk); fe = 1'b0; coin = 1'b0; serr = '0;
  endtask

  task automatic clean();
    frc = 1'b1; field(1'b1, 4'd15); frc = 1'b0;
  endtask

  task automatic go_fixed();
    clean();
    repeat (7) field(1'b1, 4'd9);
  endtask

  task automatic noise(input int n, input logic win);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); scan = win; vs = 1'b1;
      @(negedge clk); vs = 1'b0;
      @(negedge clk); scan = 1'b0;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 mode", fixed, 1'b0);
    chk("R1 req", creq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode after release", fixed, 1'b0);

    // R3: six good fields not enough, seventh enters; R9 stable between strobes
    clean();
    for (int i = 1; i <= 7; i++) begin
      field(1'b1, 4'd9);
      chk("R3 entry count", fixed, i == 7);
    end
    repeat (5) @(negedge clk);
    chk("R9 stable between boundaries", fixed, 1'b1);

    // R2 sweep: every serration count with and without coincidence
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 2; c++) begin
        clean();
        repeat (7) field(c[0], s[3:0]);
        chk("R2 good field sweep", fixed, (c == 1) && (s >= 9));
      end
    end

    // R4: a failing field (8 serrations) mid-run resets confidence
    clean();
    repeat (5) field(1'b1, 4'd10);
    field(1'b1, 4'd8);
    repeat (6) field(1'b1, 4'd10);
    chk("R4 confidence cleared", fixed, 1'b0);
    field(1'b1, 4'd10);
    chk("R4 seventh after clear", fixed, 1'b1);

    // R5: six fails hold, seventh exits
    go_fixed();
    for (int i = 1; i <= 7; i++) begin
      field(1'b1, 4'd8);
      chk("R5 loss tolerance", fixed, i < 7);
    end
    // R5: a good field restarts the failure count
    go_fixed();
    repeat (5) field(1'b0, 4'd0);
    field(1'b1, 4'd9);
    repeat (6) field(1'b0, 4'd0);
    chk("R5 miss count restarted", fixed, 1'b1);
    field(1'b0, 4'd0);
    chk("R5 exit after restart", fixed, 1'b0);

    // R6: noise arms, survives non-coincident field, coin field enters
    clean();
    noise(2, 1'b1);
    field(1'b0, 4'd0);
    chk("R6 armed but no coincidence", fixed, 1'b0);
    field(1'b1, 4'd0);
    chk("R6 fast resync", fixed, 1'b1);
    // R6: noise and coincidence in the same field
    clean();
    noise(3, 1'b1);
    field(1'b1, 4'd2);
    chk("R6 same-field resync", fixed, 1'b1);

    // R7: single pulse, out-of-window pulses, split pulses do not arm
    clean();
    noise(1, 1'b1);
    field(1'b1, 4'd0);
    chk("R7 single pulse", fixed, 1'b0);
    clean();
    noise(4, 1'b0);
    field(1'b1, 4'd0);
    chk("R7 outside window", fixed, 1'b0);
    clean();
    noise(1, 1'b1);
    field(1'b0, 4'd0);
    noise(1, 1'b1);
    field(1'b1, 4'd0);
    chk("R7 count cleared at boundary", fixed, 1'b0);

    // R8: forced async blocks entry and drops fixed mode
    clean();
    frc = 1'b1;
    repeat (8) field(1'b1, 4'd12);
    chk("R8 force blocks entry", fixed, 1'b0);
    noise(2, 1'b1);
    field(1'b1, 4'd12);
    chk("R8 force blocks fast resync", fixed, 1'b0);
    frc = 1'b0;
    go_fixed();
    frc = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 force waits for boundary", fixed, 1'b1);
    field(1'b1, 4'd12);
    chk("R8 force exits fixed", fixed, 1'b0);
    frc = 1'b0;

    // R10: reset request pulse in follow mode only
    clean();
    @(negedge clk); vs = 1'b1;
    @(negedge clk);
    chk("R10 request in follow mode", creq, 1'b1);
    @(negedge clk);
    chk("R10 request one cycle", creq, 1'b0);
    vs = 1'b0;
    go_fixed();
    @(negedge clk); vs = 1'b1;
    @(negedge clk);
    chk("R10 no request in fixed mode", creq, 1'b0);
    @(negedge clk); vs = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule